// File: doc/BRIEF.md
# Instruction-Mix Counting Analyzer

This block profiles a stored program by category without executing any of it. It holds four read-only program banks. Each bank has 256 words of 32 bits, and a load port fills the banks for testing. A start pulse latches a 2-bit bank choice and clears the eight category counters. The block then presents the words of the chosen bank one per clock on `cur_word`, beginning at address 0.

An external classifier watches `cur_word` and returns a 3-bit category code in the same cycle. For every word that is not the sentinel, the block adds one to the counter that code names. Each counter is 8 bits wide and stops at 255. The scan ends on the first word equal to the sentinel parameter, or after the word at address 255 if no sentinel appears. At that point `done` rises and stays high until the next start.

Top module: `mix_scan_top`

## Requirements
- R1: While `load_en` is high, a rising clock edge writes `load_word` into bank `load_bank` at address `load_addr`. The four banks are independent, and each holds 256 words of 32 bits.
- R2: `prog_sel` is captured on the clock edge at which `start` is high. The scan reads only the bank captured there.
- R3: The edge at which `start` is high clears all eight counters and `done`, and sets the scan address to 0. This holds even if a scan is already running.
- R4: During a scan, `cur_word` shows the word at the current address. The address advances by exactly one entry per clock, so the word at address k appears k cycles after the first.
- R5: A word equal to SENTINEL (default 32'h0000_0000) ends the scan on that edge. `done` goes high, and the sentinel itself is not counted. Counts and `done` then hold until the next start.
- R6: For each non-sentinel word in a scan, the counter for category `cat_code` (0 to 7) increases by one. Counter k sits at `cat_counts[8k+7:8k]`.
- R7: At most one counter changes on any clock edge. The decoded category enables only its own counter.
- R8: A counter at 255 stays at 255 when its category occurs again. It does not wrap.
- R9: If no sentinel is found, the word at address 255 is still classified and counted. `done` then rises on that same edge.
- R10: Changes on `prog_sel` after the start edge have no effect on the words scanned or on the counts.
- R11: A synchronous active-low reset clears all counters and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin (or restart) a scan |
| prog_sel | input | 2 | Bank to analyze, captured at start |
| load_en | input | 1 | Write enable of the load port |
| load_bank | input | 2 | Bank written by the load port |
| load_addr | input | 8 | Word address written by the load port |
| load_word | input | 32 | Data written by the load port |
| cat_code | input | 3 | Category of `cur_word`, from the external classifier |
| cur_word | output | 32 | Word at the current scan address |
| cat_counts | output | 64 | Eight 8-bit counters; counter k at bits [8k+7:8k] |
| done | output | 1 | Scan finished; held until next start |

## Verification
The bench targets these corner cases:
- A sentinel at address 0. A design that counted the sentinel, or that needed an extra cycle to stop, would report a non-zero count or a longer scan.
- A full bank with no sentinel, all in one category. This gives 256 hits, so a counter that wraps reads 0 and a scan that drops the last address reads 255 too early or never finishes.
- Exactly 255 hits followed by a sentinel, which checks the saturation boundary from the other side.
- `prog_sel` toggled at random during scans, so a design that reads the live select shows words from the wrong bank.
- Random scans over all four banks with random sentinel positions. These compare every presented word against the bench's copy of the banks, which exposes an address that skips or stalls.

// File: rtl/mix_scan_pkg.sv
// Package: shared sizes and the scan state type for the instruction-mix analyzer.
// Assumes: power-of-two bank depth and category count.
package mix_scan_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int NUM_BANKS = 4;
    localparam int CAT_W     = 3;
    localparam int CNT_W     = 8;
    localparam int NUM_CATS  = 1 << CAT_W;
    localparam int SEL_W     = $clog2(NUM_BANKS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_t;
endpackage

// File: rtl/mix_prog_store.sv
// Module: program banks with one synchronous write port and one asynchronous read port.
// Assumes: contents are not reset; writes and scans are not overlapped by the user.
module mix_prog_store #(
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 4,
    localparam int SEL_W    = $clog2(NUM_BANKS),
    localparam int DEPTH    = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] bank_out [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [WORD_W-1:0] mem [DEPTH];

        // Write this bank when the load port addresses it.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == SEL_W'(b))) begin
                mem[wr_addr] <= wr_data;
            end
        end

        // Present this bank's word at the scan address.
        always_comb begin
            bank_out[b] = mem[rd_addr];
        end
    end

    // Select the bank captured for the scan.
    always_comb begin
        rd_data = bank_out[rd_bank];
    end
endmodule

// File: rtl/mix_scan_ctrl.sv
// Module: scan sequencer; walks addresses, detects the sentinel or the last entry, raises done.
// Assumes: the word at rd_addr arrives combinationally on word_i in the same cycle.
module mix_scan_ctrl
    import mix_scan_pkg::*;
#(
    parameter int                 WORD_W   = 32,
    parameter int                 ADDR_W   = 8,
    parameter int                 SEL_W    = 2,
    parameter logic [WORD_W-1:0]  SENTINEL = '0,
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [SEL_W-1:0]  bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              count_en_o,
    output logic              clear_o,
    output logic              busy_o,
    output logic              done_o
);
    scan_state_t       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SEL_W-1:0]  bank_q;
    logic              hit_sentinel;
    logic              at_last;

    // Classify the present word as terminator or countable.
    always_comb begin
        hit_sentinel = (word_i == SENTINEL);
        at_last      = (addr_q == LAST_ADDR);
        busy_o       = (state_q == ST_SCAN);
        done_o       = (state_q == ST_DONE);
        count_en_o   = busy_o && !hit_sentinel && !start_i;
        clear_o      = start_i;
        bank_o       = bank_q;
        addr_o       = addr_q;
    end

    // Sequence the scan: restart on start, step each cycle, stop at sentinel or last entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            bank_q  <= '0;
        end else if (start_i) begin
            state_q <= ST_SCAN;
            addr_q  <= '0;
            bank_q  <= sel_i;
        end else if (state_q == ST_SCAN) begin
            if (hit_sentinel || at_last) begin
                state_q <= ST_DONE;
            end else begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mix_cat_counters.sv
// Module: one-hot category decoder feeding saturating per-category counters.
// Assumes: clear_i has priority over counting; en_i marks a countable word.
module mix_cat_counters #(
    parameter int  CAT_W    = 3,
    parameter int  CNT_W    = 8,
    localparam int NUM_CATS = 1 << CAT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear_i,
    input  logic                      en_i,
    input  logic [CAT_W-1:0]          cat_i,
    output logic [NUM_CATS*CNT_W-1:0] counts_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [NUM_CATS-1:0] sel_onehot;

    for (genvar c = 0; c < NUM_CATS; c++) begin : g_cat
        logic [CNT_W-1:0] cnt_q;

        // Decode: enable this counter only when its category is present.
        always_comb begin
            sel_onehot[c] = en_i && (cat_i == CAT_W'(c));
        end

        // Count with saturation; cleared by reset or a new scan.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                cnt_q <= '0;
            end else if (sel_onehot[c] && (cnt_q != CNT_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end

        // Place this counter in the flat output vector.
        always_comb begin
            counts_o[c*CNT_W +: CNT_W] = cnt_q;
        end
    end
endmodule

// File: rtl/mix_scan_top.sv
// Module: instruction-mix analyzer top; banks, sequencer and counters.
// Assumes: an external classifier maps cur_word to cat_code within the same cycle.
module mix_scan_top
    import mix_scan_pkg::*;
#(
    parameter logic [31:0] SENTINEL = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  prog_sel,
    input  logic        load_en,
    input  logic [1:0]  load_bank,
    input  logic [7:0]  load_addr,
    input  logic [31:0] load_word,
    input  logic [2:0]  cat_code,
    output logic [31:0] cur_word,
    output logic [63:0] cat_counts,
    output logic        done
);
    logic [SEL_W-1:0]  scan_bank;
    logic [ADDR_W-1:0] scan_addr;
    logic              count_en;
    logic              clear;
    logic              scan_busy;

    mix_prog_store #(
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_store (
        .clk     (clk),
        .wr_en   (load_en),
        .wr_bank (load_bank),
        .wr_addr (load_addr),
        .wr_data (load_word),
        .rd_bank (scan_bank),
        .rd_addr (scan_addr),
        .rd_data (cur_word)
    );

    mix_scan_ctrl #(
        .WORD_W   (WORD_W),
        .ADDR_W   (ADDR_W),
        .SEL_W    (SEL_W),
        .SENTINEL (SENTINEL)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .sel_i      (prog_sel),
        .word_i     (cur_word),
        .bank_o     (scan_bank),
        .addr_o     (scan_addr),
        .count_en_o (count_en),
        .clear_o    (clear),
        .busy_o     (scan_busy),
        .done_o     (done)
    );

    mix_cat_counters #(
        .CAT_W (CAT_W),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .en_i     (count_en),
        .cat_i    (cat_code),
        .counts_o (cat_counts)
    );
endmodule

// File: rtl/mix_scan_chk.sv
// Module: property checker for the instruction-mix analyzer, bound to the top.
// Assumes: observes ports plus the sequencer's busy flag and address.
module mix_scan_chk #(
    parameter logic [31:0] SENTINEL = 32'h0000_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        done,
    input logic        busy,
    input logic [7:0]  addr,
    input logic [31:0] cur_word,
    input logic [63:0] cat_counts
);
    // R3: a start edge leaves every counter at zero and done low.
    p_clear_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cat_counts == 64'd0 && !done));

    // R4: a running scan steps its address by one unless it has just stopped.
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (!busy || addr == $past(addr) + 8'd1));

    // R5: a sentinel seen mid-scan raises done on the next cycle.
    p_sentinel_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && cur_word == SENTINEL) |=> (done && !busy));

    // R5: once done, counts and done hold until a new start.
    p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(cat_counts)));

    for (genvar c = 0; c < 8; c++) begin : g_cnt_chk
        // R7: without a start, each counter stays or rises by exactly one.
        p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !start |=> (cat_counts[c*8 +: 8] == $past(cat_counts[c*8 +: 8]) ||
                        cat_counts[c*8 +: 8] == $past(cat_counts[c*8 +: 8]) + 8'd1));

        // R8: a counter at its ceiling does not wrap.
        p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!start && cat_counts[c*8 +: 8] == 8'hFF) |=> (cat_counts[c*8 +: 8] == 8'hFF));
    end
endmodule

bind mix_scan_top mix_scan_chk #(
    .SENTINEL (SENTINEL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .busy       (scan_busy),
    .addr       (scan_addr),
    .cur_word   (cur_word),
    .cat_counts (cat_counts)
);

// File: tb/tb_mix_scan_top.sv
// Bench: loads banks through the load port, classifies words by their low 3 bits,
// and compares presented words, scan length and counts with values computed here.
module tb_mix_scan_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  prog_sel = 2'd0;
    logic        load_en = 1'b0;
    logic [1:0]  load_bank = 2'd0;
    logic [7:0]  load_addr = 8'd0;
    logic [31:0] load_word = 32'd0;
    logic [2:0]  cat_code;
    logic [31:0] cur_word;
    logic [63:0] cat_counts;
    logic        done;

    logic [31:0] mdl [4][256];
    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    // Classifier model: category is the low three bits of the word (R6).
    assign cat_code = cur_word[2:0];

    mix_scan_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .prog_sel(prog_sel),
        .load_en(load_en), .load_bank(load_bank), .load_addr(load_addr),
        .load_word(load_word), .cat_code(cat_code), .cur_word(cur_word),
        .cat_counts(cat_counts), .done(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Number of words the scan presents: up to and including the sentinel, or all 256.
    function automatic int exp_len(input int b);
        for (int i = 0; i < 256; i++) if (mdl[b][i] == 32'd0) return i + 1;
        return 256;
    endfunction

    // Saturating per-category counts over the non-sentinel words of bank b.
    function automatic logic [63:0] exp_counts(input int b);
        logic [63:0] r = '0;
        int n = exp_len(b);
        for (int i = 0; i < n; i++) begin
            if (mdl[b][i] != 32'd0) begin
                int c = int'(mdl[b][i][2:0]);
                if (r[c*8 +: 8] != 8'hFF) r[c*8 +: 8] = r[c*8 +: 8] + 8'd1;
            end
        end
        return r;
    endfunction

    // Fill bank b: sentinel at spos (256 = none); fixed category fc, or random if fc < 0.
    task automatic fill_bank(input int b, input int spos, input int fc);
        for (int i = 0; i < 256; i++) begin
            logic [31:0] w = $urandom | 32'h100;
            if (fc >= 0) w[2:0] = 3'(fc);
            if (i == spos) w = 32'd0;
            mdl[b][i] = w;
            @(negedge clk);
            load_en = 1'b1; load_bank = 2'(b); load_addr = 8'(i); load_word = w;
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // Run one scan of bank b; optionally toggle prog_sel while it runs (R10).
    task automatic run_scan(input int b, input bit wiggle, input string tag);
        int n = 0;
        int bad = 0;
        logic [31:0] bad_act = '0, bad_exp = '0;
        logic [63:0] held;
        @(negedge clk);
        prog_sel = 2'(b); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({"R3 cleared counts ", tag}, cat_counts, 64'd0);
        check({"R3 done low after start ", tag}, {63'd0, done}, 64'd0);
        while (!done && n < 256) begin
            if (cur_word !== mdl[b][n] && bad == 0) begin
                bad = 1; bad_act = cur_word; bad_exp = mdl[b][n];
            end
            if (wiggle) prog_sel = 2'($urandom);
            n++;
            @(negedge clk);
        end
        check({"R1/R2/R4/R10 words presented in order ", tag}, {32'd0, bad_act}, {32'd0, bad_exp});
        check({"R5/R9 scan length ", tag}, 64'(n), 64'(exp_len(b)));
        check({"R6/R7/R8 counts ", tag}, cat_counts, exp_counts(b));
        held = cat_counts;
        repeat (3) @(negedge clk);
        check({"R5 done and counts hold ", tag}, {done, cat_counts[62:0]}, {1'b1, held[62:0]});
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset counts", cat_counts, 64'd0);
        check("R11 reset done", {63'd0, done}, 64'd0);

        // Directed: sentinel at address 0 counts nothing (R5).
        fill_bank(0, 0, -1);
        run_scan(0, 1'b0, "sentinel-first");
        // Directed: no sentinel, 256 hits on one category saturate (R8, R9).
        fill_bank(1, 256, 3);
        run_scan(1, 1'b0, "full-saturate");
        // Directed: exactly 255 hits then sentinel at the last entry (R8, R5).
        fill_bank(2, 255, 5);
        run_scan(2, 1'b0, "exact-255");
        // Directed: random mix with a mid-bank sentinel while select toggles (R10).
        fill_bank(3, 40, -1);
        run_scan(3, 1'b1, "select-wiggle");
        // Banks stay independent after the others were loaded (R1).
        run_scan(1, 1'b1, "bank1-again");

        // Random scans over all banks.
        for (int t = 0; t < 16; t++) begin
            int b = int'($urandom_range(0, 3));
            int s = int'($urandom_range(0, 256));
            fill_bank(b, s, -1);
            run_scan(b, t[0], "random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule